// File: doc/BRIEF.md
# Bus Initiator Latency Timer

This block limits how long a bridge may hold a secondary card bus while it acts as the initiator. Software programs an 8-bit latency value through a small register port. When the initiator raises its frame signal, the block loads a down-counter with that value. The counter then decrements once per bus clock while the transaction runs.

If the count runs out before the transaction has ended, the block raises a registered termination request. The initiator's protocol engine must then finish the transaction at the close of the next data phase, not at once. The request stays high until that data phase completes. It is also withdrawn if the transaction ends by itself.

A transaction that finishes before the count runs out stops the counter, and no request is made. Arbitration, grant handling and the rest of the bus protocol belong to neighbouring logic. This block covers only the tenure timing and the termination request.

Top module: `bus_tenure_timer`

## Requirements
- R1: After a synchronous reset, the latency register reads 00h and `term_req` is low.
- R2: A write to the latency register is visible on `lat_rd_data` one clock after the write strobe is sampled.
- R3: The counter is loaded on the clock that samples the first high cycle of `frame_act` (a low-to-high change). With a programmed value L, `term_req` rises exactly L+1 clocks after that edge. While the transaction is still running, it is low until then.
- R4: Once high, `term_req` stays high while no data-phase completion (`data_done`) and no transaction end (`xfer_end`) is sampled.
- R5: When `term_req` is high and `data_done` is sampled, `term_req` is low after that clock. It stays low for the rest of that transaction.
- R6: A programmed value of 00h counts as expired at once. `term_req` rises one clock after the frame edge, so only the first data phase completes.
- R7: Sampling `xfer_end` stops the counter and forces `term_req` low after that clock. A transaction that ends before expiry never raises `term_req`.
- R8: A register write made while a transaction is active does not change that transaction's timing. The new value applies from the next frame edge.
- R9: Every value from 01h to FFh gives the full count, including the suggested minimum of 20h and the maximum of FFh. A `data_done` pulse before expiry does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Secondary bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_wr_en | input | 1 | Latency register write strobe |
| lat_wr_data | input | 8 | Latency register write value |
| lat_rd_data | output | 8 | Registered latency register read value |
| frame_act | input | 1 | Initiator frame signal, active high |
| data_done | input | 1 | Data phase completed this cycle |
| xfer_end | input | 1 | Transaction terminated this cycle |
| term_req | output | 1 | Request to end after the next completing data phase |

## Verification
The bench builds the block with its default 8-bit counter width, so the whole programmable range is reachable in simulation. This range runs from the zero-value corner through the suggested 20h up to the 255-cycle maximum. Each expiry is checked on the exact clock where `term_req` must rise, with a check one clock earlier that it is still low. Mid-transaction writes, early endings and a stray completion strobe before expiry are each run against that cycle-exact expectation.

// File: rtl/btt_pkg.sv
package btt_pkg;
  // Per-cycle transaction events seen by the timing logic
  typedef struct packed {
    logic frame_rise;
    logic data_done;
    logic xfer_end;
  } btt_evt_t;
endpackage

// File: rtl/btt_lat_reg.sv
module btt_lat_reg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] lat_val,
  output logic [CNT_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_val <= '0;
      rd_data <= '0;
    end else if (wr_en) begin
      lat_val <= wr_data;
      rd_data <= wr_data;
    end else begin
      rd_data <= lat_val;
    end
  end
endmodule

// File: rtl/btt_frame_edge.sv
module btt_frame_edge (
  input  logic clk,
  input  logic rst,
  input  logic frame_act,
  output logic frame_rise
);
  logic frame_q;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b0;
    else     frame_q <= frame_act;
  end

  assign frame_rise = frame_act & ~frame_q;
endmodule

// File: rtl/btt_counter.sv
module btt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             stop,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= ZERO;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      running <= 1'b1;
    end else if (stop) begin
      running <= 1'b0;
    end else if (running && cnt != ZERO) begin
      cnt <= cnt - ONE;
    end
  end

  assign expired = running && (cnt == ZERO);
endmodule

// File: rtl/btt_term_ctrl.sv
module btt_term_ctrl
  import btt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  btt_evt_t evt,
  input  logic     expired,
  output logic     term_req,
  output logic     tenure_stop
);
  assign tenure_stop = evt.xfer_end | (term_req & evt.data_done);

  always_ff @(posedge clk) begin
    if (rst)                                term_req <= 1'b0;
    else if (evt.frame_rise || tenure_stop) term_req <= 1'b0;
    else if (expired)                       term_req <= 1'b1;
  end
endmodule

// File: rtl/bus_tenure_timer.sv
module bus_tenure_timer
  import btt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lat_wr_en,
  input  logic [CNT_W-1:0] lat_wr_data,
  output logic [CNT_W-1:0] lat_rd_data,
  input  logic             frame_act,
  input  logic             data_done,
  input  logic             xfer_end,
  output logic             term_req
);
  logic [CNT_W-1:0] lat_val;
  logic             frame_rise;
  logic             expired;
  logic             tenure_stop;
  btt_evt_t         evt;

  btt_lat_reg #(.CNT_W(CNT_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(lat_wr_en), .wr_data(lat_wr_data),
    .lat_val(lat_val), .rd_data(lat_rd_data)
  );

  btt_frame_edge u_edge (
    .clk(clk), .rst(rst), .frame_act(frame_act), .frame_rise(frame_rise)
  );

  assign evt = '{frame_rise: frame_rise, data_done: data_done, xfer_end: xfer_end};

  btt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(frame_rise), .stop(tenure_stop),
    .load_val(lat_val), .expired(expired)
  );

  btt_term_ctrl u_term (
    .clk(clk), .rst(rst), .evt(evt), .expired(expired),
    .term_req(term_req), .tenure_stop(tenure_stop)
  );
endmodule

// File: rtl/bus_tenure_timer_chk.sv
module bus_tenure_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             lat_wr_en,
  input logic [CNT_W-1:0] lat_wr_data,
  input logic [CNT_W-1:0] lat_rd_data,
  input logic             frame_act,
  input logic             data_done,
  input logic             xfer_end,
  input logic             term_req
);
  logic fa_q;
  logic seen_clk;
  always_ff @(posedge clk) begin
    fa_q     <= rst ? 1'b0 : frame_act;
    seen_clk <= 1'b1;
  end
  logic rise_now;
  assign rise_now = frame_act & ~fa_q;

  p_reset_r1: assert property (@(posedge clk) rst |=> (!term_req && lat_rd_data == '0));

  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    lat_wr_en |=> lat_rd_data == $past(lat_wr_data));

  p_term_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && term_req && !data_done && !xfer_end && !rise_now) |=> term_req);

  p_term_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (term_req && data_done) |=> !term_req);

  p_end_clear_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> !term_req);

  p_zero_fast_r6: assert property (@(posedge clk) disable iff (rst)
    (rise_now && lat_rd_data == '0 && !lat_wr_en && !xfer_end) |=>
      (xfer_end || data_done || rise_now || rst) or ##1 term_req);
endmodule

bind bus_tenure_timer bus_tenure_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
  .lat_rd_data(lat_rd_data), .frame_act(frame_act), .data_done(data_done),
  .xfer_end(xfer_end), .term_req(term_req)
);

// File: tb/bus_tenure_timer_tb.sv
module bus_tenure_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lat_wr_en = 1'b0;
  logic [7:0] lat_wr_data = '0;
  logic [7:0] lat_rd_data;
  logic       frame_act = 1'b0;
  logic       data_done = 1'b0;
  logic       xfer_end = 1'b0;
  logic       term_req;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  bus_tenure_timer u_dut (
    .clk(clk), .rst(rst), .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
    .lat_rd_data(lat_rd_data), .frame_act(frame_act), .data_done(data_done),
    .xfer_end(xfer_end), .term_req(term_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_lat(input logic [7:0] v);
    @(negedge clk); lat_wr_en = 1'b1; lat_wr_data = v;
    @(negedge clk); lat_wr_en = 1'b0;
  endtask

  task automatic end_xfer();
    @(negedge clk); xfer_end = 1'b1; frame_act = 1'b0;
    @(negedge clk); xfer_end = 1'b0;
  endtask

  // Raise frame, then verify term_req low after edge L and high after edge L+1
  task automatic run_expiry(input string req, input int lat);
    @(negedge clk); frame_act = 1'b1;
    for (int i = 0; i <= lat; i++) @(negedge clk);
    check(req, {7'd0, term_req}, 8'd0);
    @(negedge clk);
    check(req, {7'd0, term_req}, 8'd1);
  endtask

  task automatic t_reset();
    check("R1", lat_rd_data, 8'h00);
    check("R1", {7'd0, term_req}, 8'd0);
  endtask

  task automatic t_readback();
    @(negedge clk); lat_wr_en = 1'b1; lat_wr_data = 8'h5A;
    @(negedge clk); lat_wr_en = 1'b0;
    check("R2", lat_rd_data, 8'h5A);
  endtask

  task automatic t_basic_hold_clear();
    write_lat(8'd3);
    run_expiry("R3", 3);
    for (int i = 0; i < 4; i++) @(negedge clk);
    check("R4", {7'd0, term_req}, 8'd1);
    data_done = 1'b1;
    @(negedge clk); data_done = 1'b0;
    check("R5", {7'd0, term_req}, 8'd0);
    @(negedge clk); @(negedge clk);
    check("R5", {7'd0, term_req}, 8'd0);
    end_xfer();
  endtask

  task automatic t_zero();
    write_lat(8'd0);
    run_expiry("R6", 0);
    end_xfer();
    check("R7", {7'd0, term_req}, 8'd0);
  endtask

  task automatic t_early_end();
    write_lat(8'd6);
    @(negedge clk); frame_act = 1'b1;
    @(negedge clk); @(negedge clk);
    end_xfer();
    for (int i = 0; i < 10; i++) @(negedge clk);
    check("R7", {7'd0, term_req}, 8'd0);
  endtask

  task automatic t_mid_write();
    write_lat(8'd10);
    @(negedge clk); frame_act = 1'b1;
    @(negedge clk); lat_wr_en = 1'b1; lat_wr_data = 8'd2;
    @(negedge clk); lat_wr_en = 1'b0;
    for (int i = 0; i < 9; i++) @(negedge clk);   // after edge 10
    check("R8", {7'd0, term_req}, 8'd0);
    @(negedge clk);                                // after edge 11
    check("R8", {7'd0, term_req}, 8'd1);
    end_xfer();
    run_expiry("R8", 2);
    end_xfer();
  endtask

  task automatic t_range();
    write_lat(8'h20);
    @(negedge clk); frame_act = 1'b1;
    @(negedge clk); @(negedge clk);
    data_done = 1'b1;
    @(negedge clk); data_done = 1'b0;              // after edge 2
    for (int i = 3; i <= 32; i++) @(negedge clk);
    check("R9", {7'd0, term_req}, 8'd0);
    @(negedge clk);
    check("R9", {7'd0, term_req}, 8'd1);
    end_xfer();
    write_lat(8'hFF);
    run_expiry("R9", 255);
    end_xfer();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_basic_hold_clear();
    t_zero();
    t_early_end();
    t_mid_write();
    t_range();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule